// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery loop has reached the right frequency. It runs entirely on the reference clock. It samples a divided copy of the oscillator clock through a synchronizer and counts that signal's rising edges over a fixed window of reference cycles. At the end of each window it compares the count with the value expected for the selected data rate.

The lock test has two windows. While the loop is still acquiring, two windows in a row must each land within 1% of the expected count before lock is declared. Once the loop is tracking, lock is kept as long as the error stays within 2%. A single window outside 2% sends the loop back to acquisition.

The two outputs tell the surrounding loop whether it is locked and whether to run its phase-tracking path or its frequency-acquisition path. Changing the rate selection drops lock at once and starts a new measurement window.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is asserted and right after it is released, `locked` and `tracking` are both 0.
- R2: The window is W = 2^WIN_LOG2 reference cycles (4096 by default). The expected count is F × W / 64, where F is 10, 12, 16, 20, 24 or 28 for `rate_sel` codes 0 to 5. A window is a tight hit when |count − expected| × 100 ≤ expected. Two tight hits in a row while acquiring set `locked` and `tracking` to 1. This holds for errors of either sign.
- R3: While acquiring, a window that is not a tight hit discards an earlier single hit, so a fresh pair of consecutive hits is needed.
- R4: `locked` and `tracking` always carry the same value. They rise only at the end of a window.
- R5: While tracking, a window with |count − expected| × 50 ≤ expected keeps both flags at 1. For example, an error of 1.5% does not drop lock.
- R6: While tracking, one window with |count − expected| × 50 > expected clears both flags at the end of that window.
- R7: A signal that is 1.5% off the expected rate from the start of acquisition never reaches lock.
- R8: Any change of `rate_sel` clears both flags on the next clock edge and restarts the window. The first decision comes W cycles after the change.
- R9: With `rate_sel` code 6 or 7 the block never locks.
- R10: The divided clock passes through a two-flop synchronizer, and each of its rising edges is counted exactly once. A divided clock near the top rate (F = 28) still meets the expected count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_div | input | 1 | Divided oscillator clock, asynchronous to ref_clk |
| rate_sel | input | 3 | Selected data-rate code |
| locked | output | 1 | Frequency lock flag |
| tracking | output | 1 | 1 = phase-tracking state, 0 = frequency acquisition |

## Verification
A wrong hit counter or state would show as a lock that arrives one window early or late. Because every decision falls on a window boundary, the bench knows the exact cycle to sample after each restart. A swapped or badly scaled tolerance band shows within two windows: the 1.5% case either locks from acquisition or drops from tracking. A lost or doubled edge count shows as a failed lock at the fast rate. A restart that does not clear state shows on the cycle right after `rate_sel` changes.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_ONE_HIT = 2'd1,
    ST_TRACK   = 2'd2
  } flk_state_e;

  // Rate factor: expected edges per 64 reference cycles
  function automatic logic [31:0] rate_factor(input logic [2:0] code);
    case (code)
      3'd0:    return 32'd10;
      3'd1:    return 32'd12;
      3'd2:    return 32'd16;
      3'd3:    return 32'd20;
      3'd4:    return 32'd24;
      3'd5:    return 32'd28;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] expected_edges(input logic [2:0] code,
                                                 input int unsigned win_log2);
    return rate_factor(code) << (win_log2 - 6);
  endfunction

  function automatic logic [31:0] abs_gap(input logic [31:0] a, input logic [31:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // gap/expv <= 1/scale, evaluated without division
  function automatic logic inside_band(input logic [31:0] gap, input logic [31:0] expv,
                                       input logic [31:0] scale);
    return (expv != 32'd0) && ((gap * scale) <= expv);
  endfunction

endpackage

// File: rtl/flk_edge_sync.sv
module flk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_pulse
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign edge_pulse = pipe[STAGES-1] & ~pipe[STAGES];

  // R10
  single_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_pulse |=> !edge_pulse);

endmodule

// File: rtl/flk_window.sv
module flk_window #(
  parameter int unsigned WIN_LOG2 = 12,
  localparam int unsigned MEAS_W = WIN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              edge_pulse,
  output logic              win_done,
  output logic [MEAS_W-1:0] meas
);
  logic [WIN_LOG2-1:0] wcnt;
  logic [WIN_LOG2-1:0] ecnt;

  assign win_done = (wcnt == {WIN_LOG2{1'b1}}) && !restart;
  assign meas     = {1'b0, ecnt} + MEAS_W'(edge_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      ecnt <= '0;
    end else if (restart) begin
      wcnt <= '0;
      ecnt <= '0;
    end else begin
      wcnt <= wcnt + 1'b1;
      if (win_done) ecnt <= '0;
      else if (edge_pulse) ecnt <= ecnt + 1'b1;
    end
  end

  // R8
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !win_done);

  // R2
  win_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !win_done);

endmodule

// File: rtl/flk_lock_fsm.sv
module flk_lock_fsm #(
  parameter int unsigned WIN_LOG2 = 12,
  localparam int unsigned MEAS_W = WIN_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              win_done,
  input  logic [MEAS_W-1:0] meas,
  input  logic [2:0]        rate_q,
  output logic              locked,
  output logic              tracking
);
  import flk_pkg::*;

  flk_state_e  state, state_nx;
  logic [31:0] exp_cnt, gap;
  logic        in_tight, out_wide;

  assign exp_cnt  = expected_edges(rate_q, WIN_LOG2);
  assign gap      = abs_gap(32'(meas), exp_cnt);
  assign in_tight = inside_band(gap, exp_cnt, 32'd100);
  assign out_wide = !inside_band(gap, exp_cnt, 32'd50);

  always_comb begin
    state_nx = state;
    if (restart) begin
      state_nx = ST_SEARCH;
    end else if (win_done) begin
      case (state)
        ST_SEARCH:  state_nx = in_tight ? ST_ONE_HIT : ST_SEARCH;
        ST_ONE_HIT: state_nx = in_tight ? ST_TRACK   : ST_SEARCH;
        ST_TRACK:   state_nx = out_wide ? ST_SEARCH  : ST_TRACK;
        default:    state_nx = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SEARCH;
    else        state <= state_nx;
  end

  assign locked   = (state == ST_TRACK);
  assign tracking = (state == ST_TRACK);

  // R4
  rise_at_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_done) && $past(in_tight));

  // R3
  two_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state) == ST_ONE_HIT);

  // R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(restart) || ($past(win_done) && $past(out_wide)));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !locked && !tracking);

  // R9
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q > 3'd5) |-> !locked);

endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int unsigned WIN_LOG2    = 12,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MEAS_W = WIN_LOG2 + 1
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       vco_div,
  input  logic [2:0] rate_sel,
  output logic       locked,
  output logic       tracking
);
  logic [2:0]        rate_q;
  logic              restart;
  logic              edge_pulse;
  logic              win_done;
  logic [MEAS_W-1:0] meas;

  assign restart = (rate_sel != rate_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rate_q <= 3'd0;
    else        rate_q <= rate_sel;
  end

  flk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(ref_clk), .rst_n(rst_n), .async_in(vco_div), .edge_pulse(edge_pulse)
  );

  flk_window #(.WIN_LOG2(WIN_LOG2)) u_win (
    .clk(ref_clk), .rst_n(rst_n), .restart(restart), .edge_pulse(edge_pulse),
    .win_done(win_done), .meas(meas)
  );

  flk_lock_fsm #(.WIN_LOG2(WIN_LOG2)) u_fsm (
    .clk(ref_clk), .rst_n(rst_n), .restart(restart), .win_done(win_done),
    .meas(meas), .rate_q(rate_q), .locked(locked), .tracking(tracking)
  );

  // R1
  reset_flags_chk: assert property (@(posedge ref_clk)
    !rst_n |=> !locked && !tracking);

endmodule

// File: tb/freq_lock_det_test.sv
module freq_lock_det_test;
  localparam int CLK_PERIOD = 10;
  localparam int WL = 12;
  localparam int W  = 1 << WL;

  logic       ref_clk = 1'b0;
  logic       rst_n   = 1'b0;
  logic       vco_div;
  logic [2:0] rate_sel = 3'd0;
  logic       locked, tracking;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] acc = 16'd0;
  logic [15:0] step = 16'd0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always @(posedge ref_clk) acc <= acc + step;
  assign vco_div = acc[15];

  freq_lock_det #(.WIN_LOG2(WL)) uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .vco_div(vco_div), .rate_sel(rate_sel),
    .locked(locked), .tracking(tracking)
  );

  function automatic int factor_of(input int code);
    int f[6] = '{10, 12, 16, 20, 24, 28};
    return (code < 6) ? f[code] : 16;
  endfunction

  // dev in parts per thousand; counted edges per window = F*W/64*(1+dev/1000)
  task automatic set_vco(input int code, input int dev);
    step = 16'((1024 * factor_of(code) * (1000 + dev)) / 1000);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // both flags compared together; expected value is 0 or 3
  task automatic chk_flags(input string tag, input int exp_v);
    int act = {locked, tracking};
    checks++;
    if (act != exp_v) begin
      failures++;
      $display("FAIL %s flags actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic restart_to(input int code);
    @(negedge ref_clk); rate_sel = 3'd7;
    @(negedge ref_clk); rate_sel = 3'(code);
  endtask

  task automatic t_reset;
    chk_flags("R1 during reset", 0);
    wait_n(3); rst_n = 1'b1;
    wait_n(2);
    chk_flags("R1 after reset", 0);
  endtask

  // R2 R3 R4 R5 R6 lock, hold at 1.5%, drop at 3%
  task automatic t_lock_and_hold;
    set_vco(2, 0);
    restart_to(2);
    wait_n(W + 3);
    chk_flags("R3 one window not enough", 0);
    wait_n(W - 7);
    chk_flags("R4 no lock before second window end", 0);
    wait_n(7);
    chk_flags("R2 lock after two windows", 3);
    set_vco(2, 15);
    wait_n(2 * W);
    chk_flags("R5 hold at 1.5 percent", 3);
    set_vco(2, 30);
    wait_n(2 * W);
    chk_flags("R6 drop at 3 percent", 0);
  endtask

  // R3 hit, miss, hit, hit
  task automatic t_interrupted;
    set_vco(2, 0);
    restart_to(2);
    wait_n(W + 10);
    set_vco(2, 30);
    wait_n(W);
    set_vco(2, 0);
    wait_n(W - 7);
    chk_flags("R3 miss discards earlier hit", 0);
    wait_n(W);
    chk_flags("R3 lock after fresh pair", 3);
  endtask

  task automatic t_acq_tight;
    set_vco(2, 15);
    restart_to(2);
    wait_n(3 * W + 5);
    chk_flags("R7 no lock at 1.5 percent", 0);
  endtask

  // R10 fast rate, negative error; then R8 rate change
  task automatic t_fast_and_change;
    set_vco(5, -5);
    restart_to(5);
    wait_n(2 * W + 3);
    chk_flags("R10 lock at rate 5 minus 0.5 percent", 3);
    rate_sel = 3'd4;
    wait_n(1);
    chk_flags("R8 rate change clears flags", 0);
    wait_n(2 * W + 5);
    chk_flags("R8 wrong rate stays unlocked", 0);
  endtask

  task automatic t_bad_code;
    set_vco(6, 0);
    restart_to(6);
    wait_n(3 * W);
    chk_flags("R9 code 6 never locks", 0);
  endtask

  task automatic t_slow_rate;
    set_vco(0, 0);
    restart_to(0);
    wait_n(2 * W + 3);
    chk_flags("R2 lock at rate 0", 3);
  endtask

  initial begin
    t_reset();
    t_lock_and_hold();
    t_interrupted();
    t_acq_tight();
    t_fast_and_change();
    t_bad_code();
    t_slow_rate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule